// File: doc/BRIEF.md
# Masked Ternary-Compare CAM Core

This block holds a small array of 64-bit entries, each with its own valid flag. It searches all of them in parallel against a key. The key is either a held comparand value or the data presented with the operation. Any one of seven mask registers can be chosen for the search, and a bit set to 1 in that mask drops that bit position out of the comparison. After a search the block registers four results: a vector with one bit per matching entry, the index of the lowest matching entry, a flag for at least one match, and a flag for two or more matches.

Direct writes go to one addressed entry and mark it valid. A 3-bit field in the upper bits of the configuration word picks the mask used for writes. Bit positions that are set in that mask keep their old content. The host issues one operation per clock through an opcode, a select code, an address and a 64-bit data word. Search results hold until the next search. A combinational read port lets the host inspect any entry.

Top module: `mcam_core`

## Requirements
- R1: After reset every entry is invalid, and the comparand, all seven masks and the configuration word are zero. `match_vec`, `match_addr`, `match_flag` and `multi_flag` are all zero.
- R2: A search with select code 0 uses no mask. It reports a hit on entry i exactly when entry i is valid and equals the key in all 64 bits.
- R3: A search with select code k (1..7) uses mask register k. Bit positions where that mask is 1 do not affect the result.
- R4: An invalid entry never reports a hit, whatever its contents.
- R5: Opcode 3 searches with `op_data` as the key and also stores it in the comparand. Opcode 2 searches with `op_data` and leaves the comparand unchanged. Opcode 1 searches with the stored comparand.
- R6: Opcode 4 writes entry `op_addr` and sets its valid flag. When configuration bits [31:29] are 000, all 64 bits take `op_data`.
- R7: When configuration bits [31:29] hold k (1..7), a write keeps the old bit of the entry wherever mask register k is 1, and takes `op_data` wherever it is 0.
- R8: Search results appear one clock after the operation. `match_addr` is the lowest hitting index, or 0 if nothing hits. `match_flag` is set for one or more hits. `multi_flag` is set for two or more hits.
- R9: Operations other than searches, and cycles with `op_valid` low, leave all four search outputs unchanged.
- R10: Opcode 7 loads the full 32-bit configuration word, which reads back on `cfg_rd`. Bits [28:0] have no effect on searches or writes.
- R11: Opcode 5 clears the valid flag of entry `op_addr`.
- R12: Opcode 6 loads `op_data` into the comparand when `op_sel` is 0, and into mask register `op_sel` when it is 1..7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | 0 none, 1 search comparand, 2 search data, 3 search data and load, 4 write, 5 invalidate, 6 load register, 7 load configuration |
| op_sel | input | 3 | Mask select for searches; register select for opcode 6 |
| op_addr | input | AW (4) | Entry index for write and invalidate |
| op_data | input | 64 | Key, write data or register data |
| rd_addr | input | AW (4) | Entry index for the read port |
| rd_data | output | 64 | Contents of entry `rd_addr` |
| rd_valid | output | 1 | Valid flag of entry `rd_addr` |
| cfg_rd | output | 32 | Configuration word |
| match_vec | output | DEPTH (16) | Per-entry hit vector of the last search |
| match_addr | output | AW (4) | Lowest hitting index of the last search |
| match_flag | output | 1 | Last search hit at least one entry |
| multi_flag | output | 1 | Last search hit two or more entries |

## Verification
The hardest state to reach is an entry whose bits were partly protected by a masked write and which is then searched under a different mask. Here the write mask, the search mask and the old contents all decide the outcome together. The stimulus draws keys and write data from a small pool of related values, with single bytes flipped. Entries therefore collide often, and multiple hits and near-misses are common. Random reloads of masks and of the configuration field mix the write and search masks.

// File: rtl/mcam_pkg.sv
package mcam_pkg;
    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_CMP_REG  = 3'd1,
        OP_CMP_BUS  = 3'd2,
        OP_CMP_LOAD = 3'd3,
        OP_WRITE    = 3'd4,
        OP_INVAL    = 3'd5,
        OP_LD_REG   = 3'd6,
        OP_LD_CFG   = 3'd7
    } mcam_op_e;

    localparam int unsigned CFG_W = 32;
    localparam int unsigned SEL_W = 3;
    localparam int unsigned WSEL_LSB = CFG_W - SEL_W;
endpackage

// File: rtl/mcam_regs.sv
module mcam_regs #(
    parameter int unsigned W     = 64,
    parameter int unsigned NMASK = 7,
    parameter int unsigned CFG_W = 32,
    parameter int unsigned SEL_W = 3,
    localparam int unsigned NSLOT = 1 << SEL_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ld_reg_en,
    input  logic [SEL_W-1:0]           ld_sel,
    input  logic                       ld_cfg_en,
    input  logic                       cmp_load_en,
    input  logic [W-1:0]               wdata,
    output logic [W-1:0]               cmpd,
    output logic [NSLOT-1:0][W-1:0]    masks,
    output logic [CFG_W-1:0]           cfg
);
    typedef struct packed {
        logic [W-1:0]             cmpd;
        logic [NMASK:1][W-1:0]    mask;
        logic [CFG_W-1:0]         cfg;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld_reg_en) begin
            if (ld_sel == '0) begin
                st_d.cmpd = wdata;
            end
            for (int k = 1; k <= NMASK; k++) begin
                if (ld_sel == SEL_W'(k)) st_d.mask[k] = wdata;
            end
        end
        if (cmp_load_en) st_d.cmpd = wdata;
        if (ld_cfg_en)   st_d.cfg  = wdata[CFG_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmpd = st_q.cmpd;
    assign cfg  = st_q.cfg;

    // Slot 0 and any slot above NMASK are a zero mask: every bit active.
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        if (s == 0 || s > NMASK) begin : g_zero
            assign masks[s] = '0;
        end else begin : g_reg
            assign masks[s] = st_q.mask[s];
        end
    end
endmodule

// File: rtl/mcam_array.sv
module mcam_array #(
    parameter int unsigned W     = 64,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              inv_en,
    input  logic [AW-1:0]     addr,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      wmask,
    input  logic [W-1:0]      key,
    input  logic [W-1:0]      kmask,
    input  logic [AW-1:0]     rd_addr,
    output logic [DEPTH-1:0]  hit,
    output logic [DEPTH-1:0]  valid_vec,
    output logic [W-1:0]      rd_data,
    output logic              rd_valid
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] ent;
        logic [DEPTH-1:0]        vld;
    } arr_t;

    arr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (addr == AW'(i)) begin
                if (wr_en) begin
                    st_d.ent[i] = (st_q.ent[i] & wmask) | (wdata & ~wmask);
                    st_d.vld[i] = 1'b1;
                end else if (inv_en) begin
                    st_d.vld[i] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign hit[i] = st_q.vld[i] && (((st_q.ent[i] ^ key) & ~kmask) == '0);
    end

    assign valid_vec = st_q.vld;
    assign rd_data   = st_q.ent[rd_addr];
    assign rd_valid  = st_q.vld[rd_addr];
endmodule

// File: rtl/mcam_prio.sv
module mcam_prio #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0] req,
    output logic [AW-1:0]    idx,
    output logic             any,
    output logic             multi
);
    always_comb begin
        idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (req[i]) idx = AW'(i);
        end
        any   = |req;
        multi = (req & (req - DEPTH'(1))) != '0;
    end
endmodule

// File: rtl/mcam_core.sv
module mcam_core
    import mcam_pkg::*;
#(
    parameter int unsigned W     = 64,
    parameter int unsigned DEPTH = 16,
    parameter int unsigned NMASK = 7,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [2:0]        op_sel,
    input  logic [AW-1:0]     op_addr,
    input  logic [W-1:0]      op_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [W-1:0]      rd_data,
    output logic              rd_valid,
    output logic [31:0]       cfg_rd,
    output logic [DEPTH-1:0]  match_vec,
    output logic [AW-1:0]     match_addr,
    output logic              match_flag,
    output logic              multi_flag
);
    localparam int unsigned NSLOT = 1 << SEL_W;

    mcam_op_e op;
    logic is_cmp, is_wr, is_inv, is_ldreg, is_ldcfg, is_cload;
    logic [W-1:0] cmpd, key, kmask, wmask;
    logic [NSLOT-1:0][W-1:0] masks;
    logic [CFG_W-1:0] cfg;
    logic [DEPTH-1:0] hit, valid_vec;
    logic [AW-1:0] hit_idx;
    logic hit_any, hit_multi;

    assign op       = mcam_op_e'(op_code);
    assign is_cmp   = op_valid && (op == OP_CMP_REG || op == OP_CMP_BUS || op == OP_CMP_LOAD);
    assign is_cload = op_valid && (op == OP_CMP_LOAD);
    assign is_wr    = op_valid && (op == OP_WRITE);
    assign is_inv   = op_valid && (op == OP_INVAL);
    assign is_ldreg = op_valid && (op == OP_LD_REG);
    assign is_ldcfg = op_valid && (op == OP_LD_CFG);

    mcam_regs #(.W(W), .NMASK(NMASK), .CFG_W(CFG_W), .SEL_W(SEL_W)) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_reg_en   (is_ldreg),
        .ld_sel      (op_sel),
        .ld_cfg_en   (is_ldcfg),
        .cmp_load_en (is_cload),
        .wdata       (op_data),
        .cmpd        (cmpd),
        .masks       (masks),
        .cfg         (cfg)
    );

    assign key   = (op == OP_CMP_REG) ? cmpd : op_data;
    assign kmask = masks[op_sel];
    assign wmask = masks[cfg[CFG_W-1:WSEL_LSB]];

    mcam_array #(.W(W), .DEPTH(DEPTH)) array_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (is_wr),
        .inv_en    (is_inv),
        .addr      (op_addr),
        .wdata     (op_data),
        .wmask     (wmask),
        .key       (key),
        .kmask     (kmask),
        .rd_addr   (rd_addr),
        .hit       (hit),
        .valid_vec (valid_vec),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    mcam_prio #(.DEPTH(DEPTH)) prio_i (
        .req   (hit),
        .idx   (hit_idx),
        .any   (hit_any),
        .multi (hit_multi)
    );

    typedef struct packed {
        logic [DEPTH-1:0] vec;
        logic [AW-1:0]    addr;
        logic             flag;
        logic             multi;
    } res_t;

    res_t res_d, res_q;

    always_comb begin
        res_d = res_q;
        if (is_cmp) begin
            res_d.vec   = hit;
            res_d.addr  = hit_idx;
            res_d.flag  = hit_any;
            res_d.multi = hit_multi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign cfg_rd     = 32'(cfg);
    assign match_vec  = res_q.vec;
    assign match_addr = res_q.addr;
    assign match_flag = res_q.flag;
    assign multi_flag = res_q.multi;
endmodule

// File: rtl/mcam_core_chk.sv
module mcam_core_chk #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [2:0]       op_code,
    input logic [AW-1:0]    op_addr,
    input logic [DEPTH-1:0] valid_vec,
    input logic [DEPTH-1:0] match_vec,
    input logic [AW-1:0]    match_addr,
    input logic             match_flag,
    input logic             multi_flag
);
    logic cmp_op;
    assign cmp_op = op_valid && (op_code == 3'd1 || op_code == 3'd2 || op_code == 3'd3);

    a_r9_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_op |=> ($stable(match_vec) && $stable(match_addr) && $stable(match_flag) && $stable(multi_flag)));

    a_r4_only_valid_hit: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_op |=> ((match_vec & ~$past(valid_vec)) == '0));

    a_r8_multi_implies_match: assert property (@(posedge clk) disable iff (!rst_n)
        multi_flag |-> match_flag);

    a_r8_addr_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
        match_flag |-> match_vec[match_addr]);

    a_r8_addr_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        match_flag |-> ((match_vec & ((DEPTH'(1) << match_addr) - DEPTH'(1))) == '0));

    a_r8_no_hit_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        !match_flag |-> (match_addr == '0 && match_vec == '0));

    a_r6_write_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd4) |=> valid_vec[$past(op_addr)]);

    a_r11_inval_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd5) |=> !valid_vec[$past(op_addr)]);
endmodule

bind mcam_core mcam_core_chk #(.DEPTH(DEPTH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_code    (op_code),
    .op_addr    (op_addr),
    .valid_vec  (valid_vec),
    .match_vec  (match_vec),
    .match_addr (match_addr),
    .match_flag (match_flag),
    .multi_flag (multi_flag)
);

// File: tb/mcam_core_tb_top.sv
module mcam_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam int AW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_valid = 1'b0;
    logic [2:0] op_code = '0;
    logic [2:0] op_sel = '0;
    logic [AW-1:0] op_addr = '0;
    logic [63:0] op_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [63:0] rd_data;
    logic rd_valid;
    logic [31:0] cfg_rd;
    logic [DEPTH-1:0] match_vec;
    logic [AW-1:0] match_addr;
    logic match_flag, multi_flag;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcam_core dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_sel(op_sel), .op_addr(op_addr), .op_data(op_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid), .cfg_rd(cfg_rd),
        .match_vec(match_vec), .match_addr(match_addr),
        .match_flag(match_flag), .multi_flag(multi_flag)
    );

    // Behavioural reference state
    logic [63:0] m_ent [DEPTH];
    bit          m_val [DEPTH];
    logic [63:0] m_mask [8];
    logic [63:0] m_cmpd;
    logic [31:0] m_cfg;
    logic [DEPTH-1:0] m_vec;
    int          m_addr;
    bit          m_mf, m_mm;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) begin m_ent[i] = '0; m_val[i] = 0; end
        for (int k = 0; k < 8; k++) m_mask[k] = '0;
        m_cmpd = '0; m_cfg = '0; m_vec = '0; m_addr = 0; m_mf = 0; m_mm = 0;
    endtask

    task automatic model_apply(bit v, int code, int sel, int addr, logic [63:0] data);
        logic [63:0] key, msk;
        int cnt;
        if (!v) return;
        if (code >= 1 && code <= 3) begin
            key = (code == 1) ? m_cmpd : data;
            msk = m_mask[sel];
            cnt = 0; m_vec = '0; m_addr = 0;
            for (int i = 0; i < DEPTH; i++) begin
                if (m_val[i] && (((m_ent[i] ^ key) & ~msk) == 64'd0)) begin
                    m_vec[i] = 1'b1;
                    if (cnt == 0) m_addr = i;
                    cnt++;
                end
            end
            m_mf = (cnt > 0);
            m_mm = (cnt > 1);
            if (code == 3) m_cmpd = data;
        end else if (code == 4) begin
            msk = m_mask[m_cfg[31:29]];
            m_ent[addr] = (m_ent[addr] & msk) | (data & ~msk);
            m_val[addr] = 1;
        end else if (code == 5) begin
            m_val[addr] = 0;
        end else if (code == 6) begin
            if (sel == 0) m_cmpd = data; else m_mask[sel] = data;
        end else if (code == 7) begin
            m_cfg = data[31:0];
        end
    endtask

    task automatic check(string req, string tag, string what, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s (%s) act=%h exp=%h", req, what, tag, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        check("R2", tag, "match_vec", 64'(match_vec), 64'(m_vec));
        check("R8", tag, "match_addr", 64'(match_addr), 64'(m_addr));
        check("R8", tag, "match_flag", 64'(match_flag), 64'(m_mf));
        check("R8", tag, "multi_flag", 64'(multi_flag), 64'(m_mm));
        check("R10", tag, "cfg_rd", 64'(cfg_rd), 64'(m_cfg));
        check("R7", tag, "rd_data", rd_data, m_ent[rd_addr]);
        check("R6", tag, "rd_valid", 64'(rd_valid), 64'(m_val[rd_addr]));
    endtask

    // Called at a falling edge; returns at the next falling edge after checking.
    task automatic step(string tag, bit v, int code, int sel, int addr, logic [63:0] data, int raddr);
        op_valid = v; op_code = 3'(code); op_sel = 3'(sel);
        op_addr = AW'(addr); op_data = data; rd_addr = AW'(raddr);
        @(posedge clk);
        model_apply(v, code, sel, addr, data);
        @(negedge clk);
        compare_all(tag);
    endtask

    function automatic logic [63:0] pool(int r);
        logic [63:0] base [4];
        logic [63:0] x;
        base[0] = 64'hDEAD_BEEF_0123_4567;
        base[1] = 64'hDEAD_BEEF_89AB_CDEF;
        base[2] = 64'h0000_0000_0000_0000;
        base[3] = 64'hFFFF_0000_FFFF_0000;
        x = base[r & 3];
        if (r[2]) x = x ^ (64'hFF << (8 * ((r >> 3) & 7)));
        return x;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin : stim
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state
        compare_all("R1 reset");
        check("R1", "reset", "rd_valid", 64'(rd_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R4: search on empty array, all entries invalid (contents zero)
        step("R4 empty", 1, 2, 0, 0, 64'd0, 0);
        check("R4", "empty", "match_flag", 64'(match_flag), 64'd0);
        // R12: load masks 1..7 and comparand
        step("R12 m1", 1, 6, 1, 0, 64'h0000_0000_0000_00FF, 0);
        step("R12 m2", 1, 6, 2, 0, 64'h0000_0000_FFFF_FFFF, 0);
        step("R12 m3", 1, 6, 3, 0, 64'hFFFF_FFFF_0000_0000, 0);
        step("R12 m4", 1, 6, 4, 0, 64'hFF00_FF00_FF00_FF00, 0);
        step("R12 m5", 1, 6, 5, 0, 64'h8000_0000_0000_0001, 0);
        step("R12 m6", 1, 6, 6, 0, 64'h0F0F_0F0F_0F0F_0F0F, 0);
        step("R12 m7", 1, 6, 7, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0);
        step("R12 cmpd", 1, 6, 0, 0, 64'hDEAD_BEEF_89AB_CDEF, 0);
        // R6: unmasked writes
        step("R6 w0", 1, 4, 0, 0, 64'hDEAD_BEEF_0123_4567, 0);
        step("R6 w1", 1, 4, 0, 1, 64'hDEAD_BEEF_89AB_CDEF, 1);
        step("R6 w2", 1, 4, 0, 2, 64'h1111_2222_3333_4444, 2);
        step("R6 w5", 1, 4, 0, 5, 64'hDEAD_BEEF_89AB_CDEF, 5);
        // R2: exact search, R8 multiple hits
        step("R2 exact", 1, 2, 0, 0, 64'hDEAD_BEEF_0123_4567, 0);
        step("R8 multi", 1, 2, 0, 0, 64'hDEAD_BEEF_89AB_CDEF, 0);
        check("R8", "multi", "multi_flag", 64'(multi_flag), 64'd1);
        check("R8", "multi", "match_addr", 64'(match_addr), 64'd1);
        // R3: mask 2 ignores low half
        step("R3 mask2", 1, 2, 2, 0, 64'hDEAD_BEEF_0000_0000, 0);
        check("R3", "mask2", "match_vec", 64'(match_vec), 64'h23);
        step("R3 mask7", 1, 2, 7, 0, 64'h1234, 0);
        // R5: search from comparand, then load and check no-load variant
        step("R5 cmpreg", 1, 1, 0, 0, 64'd0, 0);
        step("R5 cload", 1, 3, 0, 0, 64'h1111_2222_3333_4444, 2);
        step("R5 cbus", 1, 2, 0, 0, 64'hDEAD_BEEF_0123_4567, 0);
        step("R5 cmpreg2", 1, 1, 0, 0, 64'd0, 2);
        check("R5", "cmpreg2", "match_addr", 64'(match_addr), 64'd2);
        // R9: non-search ops and idle keep results
        step("R9 idle", 0, 1, 0, 0, 64'd0, 0);
        step("R9 nop", 1, 0, 0, 0, 64'd0, 0);
        // R10/R7: config selects mask 4 for writes, reserved bits set
        step("R10 cfg", 1, 7, 0, 0, 64'h8ABC_DEF1, 0);
        step("R7 mwrite", 1, 4, 0, 0, 64'h0000_0000_0000_0000, 0);
        check("R7", "mwrite", "rd_data", rd_data, 64'hDE00_BE00_0100_4500);
        step("R10 cfg0", 1, 7, 0, 0, 64'h1FFF_FFFF, 0);
        step("R10 unmasked", 1, 4, 0, 3, 64'hAAAA_5555_AAAA_5555, 3);
        // R11: invalidate and search again
        step("R11 inv", 1, 5, 0, 1, 64'd0, 1);
        step("R11 search", 1, 2, 0, 0, 64'hDEAD_BEEF_89AB_CDEF, 1);
        check("R11", "search", "match_addr", 64'(match_addr), 64'd5);
        // Random traffic
        for (int n = 0; n < 4000; n++) begin
            int r, code, sel;
            logic [63:0] d;
            r = int'($urandom);
            code = int'($urandom_range(0, 7));
            if (code == 6 && ($urandom_range(0, 3) != 0)) code = 4;
            sel = int'($urandom_range(0, 7));
            d = pool(r);
            if (code == 6 && sel != 0) d = 64'hFF << (8 * int'($urandom_range(0, 7)));
            if (code == 7) d = {32'd0, 3'(sel), 29'($urandom)};
            step("R2 random", ($urandom_range(0, 9) != 0), code, sel,
                 int'($urandom_range(0, DEPTH-1)), d, int'($urandom_range(0, DEPTH-1)));
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule